// File: doc/BRIEF.md
# Edge/Level Interrupt Capture Dispatcher

This block gathers a parameterised number of interrupt sources, from 1 to 64 (`NUM_SRC`). Each source can be set to capture a rising edge or to follow its input level. The block keeps a request bit and an in-service bit for every source. It steers each source that is accepted to one upstream line, chosen by an 8-bit vector entry kept for that source. Masking is loaded through a strobe. Clearing of latched edge requests is done with a separate strobe.

Every cycle the block follows the input lines to keep the request vector current. It then runs at most one evaluation, taking the event sources in priority order: a clear, then a mask load, then input changes. An evaluation can raise one upstream line, the line mapped to the lowest-numbered pending source. It can also drop one line, the line mapped to the lowest-numbered in-service source among those affected. Upstream lines are registered, so a change on them appears on the clock edge that samples the event.

Top module: `irq_capture_dispatch`

## Requirements
- R1: Reset leaves every source masked, the request, in-service and last-seen vectors at zero, and every upstream line low. Inputs that are high when reset ends raise no line until the sources are unmasked.
- R2: In edge mode (`edgeSel` bit = 1), the request bit is set when the input is high and its last-seen level was low. A falling input leaves the request bit set.
- R3: In level mode (`edgeSel` bit = 0), the request bit equals the input level, so a source whose input has fallen has nothing pending.
- R4: On a rising input, the lowest-numbered source that rose, is requesting and is unmasked (mask bit = 0) is marked in service. Upstream line `vecTable[8*i +: 8]` of that source goes high, visible after the clock edge that sampled the input and not before it.
- R5: On a falling input, the lowest-numbered source that fell and is in service leaves service, and its mapped upstream line goes low.
- R6: A clear strobe acts only on the bits of `clearBits` that select edge-mode sources. Those sources lose their request bit and their in-service bit, and the mapped line of the lowest one that was in service goes low. Level-mode sources are not changed.
- R7: A mask load replaces the mask with `maskIn`. Sources that become unmasked are evaluated for assertion, so the lowest one that is requesting raises its line. Sources that become masked are evaluated for deassertion, so the lowest one in service drops its line.
- R8: When several sources change in the same cycle, only the lowest-numbered one is dispatched. The others keep their request bits but raise no line until a later evaluation touches them.
- R9: A clear strobe takes priority over a mask load in the same cycle, and the mask load is then discarded. Both strobes take priority over input dispatch. Input edges that arrive during a strobe cycle still update the request vector.
- R10: A vector entry whose value is at or above `NUM_OUT` drives no upstream line, but the source still enters service.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Block clock |
| rst | input | 1 | Synchronous active-high reset |
| lineIn | input | NUM_SRC | Interrupt source lines, already synchronised |
| edgeSel | input | NUM_SRC | 1 = edge mode, 0 = level mode, per source |
| maskIn | input | NUM_SRC | New mask value, 1 = masked |
| maskLoad | input | 1 | Loads `maskIn` into the mask and runs the mask evaluations |
| clearBits | input | NUM_SRC | Sources to clear when `clearStrobe` is high |
| clearStrobe | input | 1 | Runs a clear on the edge-mode bits of `clearBits` |
| vecTable | input | NUM_SRC*8 | Upstream line index per source, source i at bits 8*i+7:8*i |
| upIrq | output | NUM_OUT | Registered upstream interrupt lines |

## Verification
The embedded properties check, on every cycle, that upstream lines stay low during reset. They also check that no more than one line rises and no more than one falls per cycle, that a clear never raises a line, and that a cycle with only falling inputs raises nothing. The scenarios cover the rest: edge requests that survive while masked and appear on unmasking, level requests that vanish, clear reaching only edge sources, strobe priority with request tracking continuing underneath, lowest-index selection among simultaneous changes, and vector entries out of range.

// File: rtl/irq_dispatch_pkg.sv
package irq_dispatch_pkg;
  // Which event source the datapath evaluates this cycle (at most one set).
  typedef struct packed {
    logic doClear;
    logic doMask;
    logic doInput;
  } evtSel_t;
endpackage

// File: rtl/irq_low_pick.sv
module irq_low_pick #(
  parameter int W  = 8,
  localparam int IW = (W > 1) ? $clog2(W) : 1
) (
  input  logic [W-1:0]  cand,
  output logic          found,
  output logic [IW-1:0] idx
);
  always_comb begin
    found = 1'b0;
    idx   = '0;
    for (int i = W - 1; i >= 0; i--) begin
      if (cand[i]) begin
        found = 1'b1;
        idx   = IW'(i);
      end
    end
  end
endmodule

// File: rtl/irq_dispatch_ctrl.sv
module irq_dispatch_ctrl
  import irq_dispatch_pkg::*;
(
  input  logic    clearStrobe,
  input  logic    maskLoad,
  output evtSel_t sel
);
  // Fixed priority: clear, then mask load, then input changes.
  always_comb begin
    sel.doClear = clearStrobe;
    sel.doMask  = maskLoad & ~clearStrobe;
    sel.doInput = ~maskLoad & ~clearStrobe;
  end
endmodule

// File: rtl/irq_dispatch_dp.sv
module irq_dispatch_dp
  import irq_dispatch_pkg::*;
#(
  parameter int NUM_SRC = 64,
  parameter int NUM_OUT = 256,
  parameter int VEC_W   = 8,
  localparam int IW = (NUM_SRC > 1) ? $clog2(NUM_SRC) : 1,
  localparam int OW = (NUM_OUT > 1) ? $clog2(NUM_OUT) : 1
) (
  input  logic                     clk,
  input  logic                     rst,
  input  evtSel_t                  sel,
  input  logic [NUM_SRC-1:0]       lineIn,
  input  logic [NUM_SRC-1:0]       edgeSel,
  input  logic [NUM_SRC-1:0]       maskIn,
  input  logic [NUM_SRC-1:0]       clearBits,
  input  logic [NUM_SRC*VEC_W-1:0] vecTable,
  output logic [NUM_OUT-1:0]       upIrq
);
  logic [NUM_SRC-1:0] reqVec, inSvc, lastSeen, maskVec;
  logic [NUM_SRC-1:0] riseVec, fallVec, reqTrack, reqNext, maskNext, clrEdge;
  logic [NUM_SRC-1:0] assertSet, deassertSet, pendVec, svcCand, inSvcNext;
  logic [NUM_OUT-1:0] upNext;
  logic [VEC_W-1:0]   vecArr [NUM_SRC];
  logic               aFound, dFound;
  logic [IW-1:0]      aIdx, dIdx;
  logic [VEC_W-1:0]   aLine, dLine;

  for (genvar g = 0; g < NUM_SRC; g++) begin : g_vec
    assign vecArr[g] = vecTable[g*VEC_W +: VEC_W];
  end

  // Request tracking runs every cycle whatever the event source.
  assign riseVec  = lineIn & ~lastSeen;
  assign fallVec  = ~lineIn & lastSeen;
  assign reqTrack = (edgeSel & (reqVec | riseVec)) | (~edgeSel & lineIn);
  assign clrEdge  = sel.doClear ? (clearBits & edgeSel) : '0;
  assign reqNext  = reqTrack & ~clrEdge;
  assign maskNext = sel.doMask ? maskIn : maskVec;

  always_comb begin
    assertSet   = '0;
    deassertSet = '0;
    if (sel.doClear) begin
      deassertSet = clrEdge;
    end else if (sel.doMask) begin
      assertSet   = maskVec & ~maskIn;
      deassertSet = ~maskVec & maskIn;
    end else if (sel.doInput) begin
      assertSet   = riseVec;
      deassertSet = fallVec;
    end
  end

  assign pendVec = assertSet & reqNext & ~maskNext;
  assign svcCand = deassertSet & inSvc;

  irq_low_pick #(.W(NUM_SRC)) u_pickAssert   (.cand(pendVec), .found(aFound), .idx(aIdx));
  irq_low_pick #(.W(NUM_SRC)) u_pickDeassert (.cand(svcCand), .found(dFound), .idx(dIdx));

  assign aLine = vecArr[aIdx];
  assign dLine = vecArr[dIdx];

  always_comb begin
    inSvcNext = inSvc;
    if (aFound) inSvcNext[aIdx] = 1'b1;
    if (dFound) inSvcNext[dIdx] = 1'b0;
    inSvcNext = inSvcNext & ~clrEdge;
    upNext = upIrq;
    if (aFound && (int'(aLine) < NUM_OUT)) upNext[aLine[OW-1:0]] = 1'b1;
    if (dFound && (int'(dLine) < NUM_OUT)) upNext[dLine[OW-1:0]] = 1'b0;
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      reqVec   <= '0;
      inSvc    <= '0;
      lastSeen <= '0;
      maskVec  <= '1;
      upIrq    <= '0;
    end else begin
      reqVec   <= reqNext;
      inSvc    <= inSvcNext;
      lastSeen <= lineIn;
      maskVec  <= maskNext;
      upIrq    <= upNext;
    end
  end

  // R1: reset drives every upstream line low
  p_reset_idle_r1: assert property (@(posedge clk) rst |=> (upIrq == '0));

  // R4: a single evaluation raises at most one line
  p_single_rise_r4: assert property (@(posedge clk) disable iff (rst)
    $countones(upIrq & ~$past(upIrq)) <= 1);

  // R5: a single evaluation drops at most one line
  p_single_fall_r5: assert property (@(posedge clk) disable iff (rst)
    $countones(~upIrq & $past(upIrq)) <= 1);

  // R6: a clear cycle never raises a line
  p_clear_no_rise_r6: assert property (@(posedge clk) disable iff (rst)
    sel.doClear |=> ((upIrq & ~$past(upIrq)) == '0));

  // R5: a cycle with only falling inputs never raises a line
  p_fall_no_rise_r5: assert property (@(posedge clk) disable iff (rst)
    (sel.doInput && (riseVec == '0)) |=> ((upIrq & ~$past(upIrq)) == '0));
endmodule

// File: rtl/irq_capture_dispatch.sv
module irq_capture_dispatch
  import irq_dispatch_pkg::*;
#(
  parameter int NUM_SRC = 64,
  parameter int NUM_OUT = 256,
  localparam int VEC_W  = 8
) (
  input  logic                     clk,
  input  logic                     rst,
  input  logic [NUM_SRC-1:0]       lineIn,
  input  logic [NUM_SRC-1:0]       edgeSel,
  input  logic [NUM_SRC-1:0]       maskIn,
  input  logic                     maskLoad,
  input  logic [NUM_SRC-1:0]       clearBits,
  input  logic                     clearStrobe,
  input  logic [NUM_SRC*VEC_W-1:0] vecTable,
  output logic [NUM_OUT-1:0]       upIrq
);
  evtSel_t sel;

  irq_dispatch_ctrl u_ctrl (
    .clearStrobe(clearStrobe),
    .maskLoad   (maskLoad),
    .sel        (sel)
  );

  irq_dispatch_dp #(.NUM_SRC(NUM_SRC), .NUM_OUT(NUM_OUT), .VEC_W(VEC_W)) u_dp (
    .clk      (clk),
    .rst      (rst),
    .sel      (sel),
    .lineIn   (lineIn),
    .edgeSel  (edgeSel),
    .maskIn   (maskIn),
    .clearBits(clearBits),
    .vecTable (vecTable),
    .upIrq    (upIrq)
  );
endmodule

// File: tb/irq_capture_dispatch_bench.sv
module irq_capture_dispatch_bench;
  localparam int NS = 8;
  localparam int NO = 16;

  typedef struct packed {
    logic [7:0]  lin;
    logic        mStb;
    logic [7:0]  mVal;
    logic        cStb;
    logic [7:0]  cVal;
    logic [15:0] expUp;
    logic [7:0]  tag;
  } step_t;

  // Sources 0-3 edge mode, 4-7 level mode. Source i maps to line i+4,
  // source 7 maps to 200 (out of range for 16 lines).
  localparam step_t TBL [22] = '{
    '{8'h00, 1'b0, 8'h00, 1'b0, 8'h00, 16'h0000, 8'd1},  // R1 idle
    '{8'h01, 1'b0, 8'h00, 1'b0, 8'h00, 16'h0000, 8'd2},  // R2 masked edge
    '{8'h00, 1'b0, 8'h00, 1'b0, 8'h00, 16'h0000, 8'd2},  // R2 fall keeps req
    '{8'h10, 1'b0, 8'h00, 1'b0, 8'h00, 16'h0000, 8'd3},  // R3 masked level
    '{8'h00, 1'b0, 8'h00, 1'b0, 8'h00, 16'h0000, 8'd3},  // R3 level drops
    '{8'h00, 1'b1, 8'hEE, 1'b0, 8'h00, 16'h0010, 8'd7},  // R7 unmask 0,4
    '{8'h10, 1'b0, 8'h00, 1'b0, 8'h00, 16'h0110, 8'd4},  // R4 level rise
    '{8'h00, 1'b0, 8'h00, 1'b0, 8'h00, 16'h0010, 8'd5},  // R5 level fall
    '{8'h10, 1'b0, 8'h00, 1'b0, 8'h00, 16'h0110, 8'd4},  // R4 again
    '{8'h10, 1'b0, 8'h00, 1'b1, 8'h11, 16'h0100, 8'd6},  // R6 clear
    '{8'h10, 1'b1, 8'hFF, 1'b0, 8'h00, 16'h0000, 8'd7},  // R7 mask all
    '{8'h10, 1'b1, 8'hEE, 1'b0, 8'h00, 16'h0100, 8'd6},  // R6 src0 req gone
    '{8'h10, 1'b1, 8'h00, 1'b0, 8'h00, 16'h0100, 8'd7},  // R7 unmask all
    '{8'h16, 1'b0, 8'h00, 1'b0, 8'h00, 16'h0120, 8'd8},  // R8 two rise
    '{8'h16, 1'b0, 8'h00, 1'b0, 8'h00, 16'h0120, 8'd8},  // R8 src2 waits
    '{8'h1E, 1'b1, 8'h00, 1'b0, 8'h00, 16'h0120, 8'd9},  // R9 masked dispatch
    '{8'h1E, 1'b0, 8'h00, 1'b1, 8'h06, 16'h0100, 8'd6},  // R6 clear 1,2
    '{8'h1E, 1'b1, 8'hFF, 1'b0, 8'h00, 16'h0000, 8'd7},  // R7 mask all
    '{8'h1E, 1'b1, 8'h00, 1'b0, 8'h00, 16'h0080, 8'd9},  // R9 src3 tracked
    '{8'h9E, 1'b0, 8'h00, 1'b0, 8'h00, 16'h0080, 8'd10}, // R10 no line
    '{8'h9E, 1'b1, 8'hFF, 1'b1, 8'h08, 16'h0000, 8'd9},  // R9 clear wins
    '{8'hDE, 1'b0, 8'h00, 1'b0, 8'h00, 16'h0400, 8'd9}   // R9 mask unchanged
  };

  logic          clk = 1'b0;
  logic          rst = 1'b1;
  logic [NS-1:0] lineIn = '0, maskIn = '0, clearBits = '0;
  logic [NS-1:0] edgeSel = 8'h0F;
  logic          maskLoad = 1'b0, clearStrobe = 1'b0;
  logic [NS*8-1:0] vecTable = {8'hC8, 8'h0A, 8'h09, 8'h08, 8'h07, 8'h06, 8'h05, 8'h04};
  logic [NO-1:0] upIrq;
  int errors = 0, checks = 0;
  bit done = 1'b0;

  always #4 clk = ~clk;

  irq_capture_dispatch #(.NUM_SRC(NS), .NUM_OUT(NO)) u_irq_capture_dispatch (
    .clk(clk), .rst(rst), .lineIn(lineIn), .edgeSel(edgeSel), .maskIn(maskIn),
    .maskLoad(maskLoad), .clearBits(clearBits), .clearStrobe(clearStrobe),
    .vecTable(vecTable), .upIrq(upIrq)
  );

  task automatic check(input string req, input logic [NO-1:0] act, input logic [NO-1:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s: upIrq=%h expected %h", req, act, exp);
    end
  endtask

  task automatic finish_run();
    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  endtask

  initial begin
    #400000;
    if (!done) begin
      errors++;
      checks++;
      $display("FAIL watchdog: run did not complete");
      finish_run();
    end
  end

  initial begin
    repeat (3) @(negedge clk);
    check("R1 during reset", upIrq, '0);
    rst = 1'b0;
    foreach (TBL[i]) begin
      lineIn      = TBL[i].lin;
      maskLoad    = TBL[i].mStb;
      maskIn      = TBL[i].mVal;
      clearStrobe = TBL[i].cStb;
      clearBits   = TBL[i].cVal;
      @(negedge clk);
      check($sformatf("R%0d step %0d", TBL[i].tag, i), upIrq, TBL[i].expUp);
    end
    maskLoad = 1'b0; clearStrobe = 1'b0;

    // R1: reset with inputs high, sources stay masked afterwards
    rst = 1'b1;
    @(negedge clk);
    check("R1 reset clears lines", upIrq, '0);
    rst = 1'b0;
    repeat (2) @(negedge clk);
    check("R1 masked after reset", upIrq, '0);

    // R7: unmask source 1 only (edge request captured after reset)
    maskLoad = 1'b1; maskIn = 8'hFD;
    check("R4 not before edge", upIrq, '0);
    @(negedge clk);
    maskLoad = 1'b0;
    check("R7 unmask one source", upIrq, 16'h0020);

    // R4: registered timing, change shows only after the sampling edge
    maskLoad = 1'b1; maskIn = 8'hED;
    #1;
    check("R4 output registered", upIrq, 16'h0020);
    @(negedge clk);
    maskLoad = 1'b0;
    check("R4 level source raised", upIrq, 16'h0120);

    // R5: falling edge-mode source drops its line
    lineIn = 8'hDC;
    @(negedge clk);
    check("R5 edge source fall", upIrq, 16'h0100);

    done = 1'b1;
    finish_run();
  end
endmodule